// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Write Unpacking

This block sits between a host register port and an audio serial encoder. The host writes 32-bit words. Each accepted word is turned into one or two samples, as set by the write mode. Samples are held as left/right pairs in a small circular store. The encoder reads the oldest pair through a pop strobe. A mono sample is repeated into both channels of its pair.

Compact modes carry two narrow samples per word. Each narrow sample is widened to a 32-bit entry, placed at the top of the word, with zeros below it. In plain stereo mode, one word is one channel sample. The block holds the left sample until the matching right sample arrives, and it shows which channel the next word will fill.

The fill level counts channel samples, so a stored pair or a mono sample adds two. A left sample that is still waiting for its right partner adds one. Any change of configuration empties the store. A write that finds no room is lost and raises a sticky overflow flag.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1, `full` is 0, `out_valid` is 0, `next_right` is 0 and `overflow` is 0.
- R2: Stereo mode (`wr_mode` 0; code 3 acts the same) stores one full 32-bit sample per write. The first write is left and the second is right, and `next_right` is 1 between them. Each channel sample adds 1 to `level`.
- R3: Compact 16-bit mode (`wr_mode` 1, `compact8` 0) takes one write and stores right = {`wr_data[31:16]`, 16 zeros} and left = {`wr_data[15:0]`, 16 zeros}. It adds 2 to `level`.
- R4: Compact 8-bit mode (`wr_mode` 1, `compact8` 1) takes one write and stores right = {`wr_data[15:8]`, 24 zeros} and left = {`wr_data[7:0]`, 24 zeros}. It adds 2 to `level`. Bits 31:16 are ignored.
- R5: Mono mode (`wr_mode` 2) stores the whole write as both left and right, and adds 2 to `level`.
- R6: The store holds eight pairs. `full` is 1 exactly when `level` is 16. A write while full is dropped, even if a pop happens in the same cycle. The dropped write sets `overflow`, and `overflow` stays set until reset.
- R7: A pop while `out_valid` is 0 changes nothing: `level` and `next_right` keep their values.
- R8: A cycle in which `wr_mode` or `compact8` differs from the configuration in use empties the store. That cycle also clears `next_right` and discards any write presented in it. From the next cycle, `level` is 0.
- R9: Pairs leave in the order they were written. `out_left` and `out_right` show the oldest pair whenever `out_valid` is 1. A pop and a write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 2 | Write mode: 0 stereo, 1 compact, 2 mono, 3 stereo |
| compact8 | input | 1 | Compact sample width: 0 selects 16-bit, 1 selects 8-bit |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| pop | input | 1 | Encoder takes the oldest pair |
| out_left | output | 32 | Left sample of the oldest pair |
| out_right | output | 32 | Right sample of the oldest pair |
| out_valid | output | 1 | At least one pair is stored |
| level | output | 5 | Fill level in channel samples, 0 to 16 |
| next_right | output | 1 | The next stereo write fills the right channel |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level is sixteen |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The bench checks field placement in both compact widths with distinct upper and lower patterns. A swapped or unshifted channel then shows up as a wrong word on `out_left` or `out_right`. It fills the store with mono samples up to sixteen and writes one more. A design that miscounts mono samples, or that accepts a write while full, gives a wrong `level`, misses the overflow, or changes the pop order. It pops an empty store to catch a level that underflows. It switches modes with a write in the same cycle. A design that leaks that write, or keeps a half-written stereo left, leaves a nonzero level afterwards. Writes combined with pops at full and near-full occupancy expose a design that decides fullness after the pop.

// File: rtl/atx_pkg.sv
package atx_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        WM_STEREO  = 2'd0,
        WM_COMPACT = 2'd1,
        WM_MONO    = 2'd2,
        WM_RSVD    = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        WK_LEFT,
        WK_RIGHT,
        WK_PAIR
    } wkind_e;

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } pair_t;

    function automatic logic [WORD_W-1:0] widen16(input logic [15:0] s);
        return {s, {(WORD_W-16){1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] widen8(input logic [7:0] s);
        return {s, {(WORD_W-8){1'b0}}};
    endfunction

endpackage

// File: rtl/atx_unpack.sv
module atx_unpack
    import atx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  wmode_e            mode,
    input  logic              narrow8,
    input  logic              want_right,
    output wkind_e            kind,
    output pair_t             pair
);

    always_comb begin
        kind = WK_PAIR;
        pair = '0;
        unique case (mode)
            WM_COMPACT: begin
                if (narrow8) begin
                    pair.left  = widen8(word[7:0]);
                    pair.right = widen8(word[15:8]);
                end else begin
                    pair.left  = widen16(word[15:0]);
                    pair.right = widen16(word[31:16]);
                end
            end
            WM_MONO: begin
                pair.left  = word;
                pair.right = word;
            end
            default: begin
                kind       = want_right ? WK_RIGHT : WK_LEFT;
                pair.left  = word;
                pair.right = word;
            end
        endcase
    end

endmodule

// File: rtl/atx_pair_store.sv
module atx_pair_store
    import atx_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  pair_t         push_pair,
    input  logic          pop,
    output pair_t         head,
    output logic [CW-1:0] count
);

    pair_t         slots [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = slots[rptr];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst)
            slots[wptr] <= push_pair;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import atx_pkg::*;
#(
    parameter  int PAIR_DEPTH = 8,
    localparam int LVL_W      = $clog2(2 * PAIR_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        wr_mode,
    input  logic              compact8,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pop,
    output logic [WORD_W-1:0] out_left,
    output logic [WORD_W-1:0] out_right,
    output logic              out_valid,
    output logic [LVL_W-1:0]  level,
    output logic              next_right,
    output logic              empty,
    output logic              full,
    output logic              overflow
);

    localparam int CW = $clog2(PAIR_DEPTH + 1);

    wmode_e            mode_q;
    logic              narrow_q;
    logic              cfg_chg;
    logic [WORD_W-1:0] hold_q;
    logic              right_q;
    logic              ovf_q;

    wkind_e            kind;
    pair_t             unpacked;
    pair_t             push_pair;
    pair_t             head;
    logic [CW-1:0]     count;
    logic              store_full;
    logic              wr_go;
    logic              push;

    assign cfg_chg    = (wmode_e'(wr_mode) != mode_q) || (compact8 != narrow_q);
    assign store_full = (count == CW'(PAIR_DEPTH));
    assign wr_go      = wr_en && !cfg_chg;
    assign push       = wr_go && !store_full && (kind != WK_LEFT);

    atx_unpack u_unpack (
        .word       (wr_data),
        .mode       (mode_q),
        .narrow8    (narrow_q),
        .want_right (right_q),
        .kind       (kind),
        .pair       (unpacked)
    );

    always_comb begin
        push_pair = unpacked;
        if (kind == WK_RIGHT)
            push_pair.left = hold_q;
    end

    atx_pair_store #(.DEPTH(PAIR_DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg_chg),
        .push      (push),
        .push_pair (push_pair),
        .pop       (pop),
        .head      (head),
        .count     (count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= wmode_e'(wr_mode);
            narrow_q <= compact8;
            hold_q   <= '0;
            right_q  <= 1'b0;
            ovf_q    <= 1'b0;
        end else if (cfg_chg) begin
            mode_q   <= wmode_e'(wr_mode);
            narrow_q <= compact8;
            right_q  <= 1'b0;
        end else if (wr_go) begin
            if (store_full) begin
                ovf_q <= 1'b1;
            end else if (kind == WK_LEFT) begin
                hold_q  <= wr_data;
                right_q <= 1'b1;
            end else if (kind == WK_RIGHT) begin
                right_q <= 1'b0;
            end
        end
    end

    assign out_left   = head.left;
    assign out_right  = head.right;
    assign out_valid  = (count != '0);
    assign level      = LVL_W'({count, 1'b0}) + LVL_W'(right_q);
    assign next_right = right_q;
    assign empty      = (level == '0);
    assign full       = store_full;
    assign overflow   = ovf_q;

endmodule

// File: rtl/atx_checker.sv
module atx_checker #(
    parameter int PAIR_DEPTH = 8,
    parameter int LVL_W      = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             pop,
    input logic             cfg_chg,
    input logic [1:0]       mode_q,
    input logic [LVL_W-1:0] level,
    input logic             next_right,
    input logic             out_valid,
    input logic             full,
    input logic             overflow
);

    // R6: level never exceeds two per pair slot
    p_level_bound_r6: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(2 * PAIR_DEPTH));

    // R6: full coincides with the top level
    p_full_level_r6: assert property (@(posedge clk) disable iff (rst)
        full |-> (level == LVL_W'(2 * PAIR_DEPTH)));

    // R6: a write at full sets the flag
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !cfg_chg) |=> overflow);

    // R6: flag is sticky
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R7: pop on empty store with no other activity leaves state alone
    p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && !out_valid && !wr_en && !cfg_chg) |=> ($stable(level) && $stable(next_right)));

    // R8: configuration change empties the store
    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_chg |=> (level == '0 && !next_right));

    // R5: an accepted mono write adds two
    p_mono_step_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cfg_chg && mode_q == 2'd2 && !full && !pop) |=> (level == $past(level) + LVL_W'(2)));

endmodule

bind audio_tx_fifo atx_checker #(.PAIR_DEPTH(PAIR_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .pop        (pop),
    .cfg_chg    (cfg_chg),
    .mode_q     (mode_q),
    .level      (level),
    .next_right (next_right),
    .out_valid  (out_valid),
    .full       (full),
    .overflow   (overflow)
);

// File: tb/sim_audio_tx_fifo.sv
module sim_audio_tx_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    typedef struct packed {
        logic [31:0] l;
        logic [31:0] r;
    } epair_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  wr_mode = 2'd0;
    logic        compact8 = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pop = 1'b0;
    logic [31:0] out_left, out_right;
    logic        out_valid, next_right, empty, full, overflow;
    logic [4:0]  level;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    epair_t      exp_q[$];
    bit          m_right = 0;
    bit          m_ovf   = 0;
    logic [31:0] m_hold  = '0;
    logic [1:0]  m_mode  = 2'd0;
    bit          m_c8    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_tx_fifo u0 (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .compact8(compact8),
        .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
        .out_left(out_left), .out_right(out_right), .out_valid(out_valid),
        .level(level), .next_right(next_right), .empty(empty),
        .full(full), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // state seen at the ports against the model
    task automatic chk_state(input string req);
        chk(req, 32'(level), 32'(2 * exp_q.size() + int'(m_right)));
        chk(req, 32'(next_right), 32'(m_right));
        chk(req, 32'(full), 32'(exp_q.size() == DEPTH));
        chk(req, 32'(empty), 32'(exp_q.size() == 0 && !m_right));
        chk(req, 32'(overflow), 32'(m_ovf));
    endtask

    // driver side of the scoreboard: predict the effect of one write
    function automatic void model_write(input logic [31:0] d, input bit was_full);
        epair_t p;
        if (m_mode == 2'd1) begin
            if (m_c8) begin p.l = {d[7:0], 24'h0};  p.r = {d[15:8], 24'h0};  end
            else      begin p.l = {d[15:0], 16'h0}; p.r = {d[31:16], 16'h0}; end
            if (was_full) m_ovf = 1; else exp_q.push_back(p);
        end else if (m_mode == 2'd2) begin
            p.l = d; p.r = d;
            if (was_full) m_ovf = 1; else exp_q.push_back(p);
        end else if (!m_right) begin
            if (was_full) m_ovf = 1; else begin m_hold = d; m_right = 1; end
        end else begin
            p.l = m_hold; p.r = d;
            if (was_full) m_ovf = 1; else begin exp_q.push_back(p); m_right = 0; end
        end
    endfunction

    task automatic do_write(input logic [31:0] d, input string req);
        bit was_full;
        @(negedge clk);
        was_full = (exp_q.size() == DEPTH);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model_write(d, was_full);
        chk_state(req);
    endtask

    // monitor side: compare the head with the oldest expected pair, then take it
    task automatic do_pop(input string req);
        @(negedge clk);
        if (exp_q.size() > 0) begin
            chk({req, " left"},  out_left,  exp_q[0].l);
            chk({req, " right"}, out_right, exp_q[0].r);
            chk({req, " valid"}, 32'(out_valid), 32'd1);
        end else begin
            chk({req, " valid"}, 32'(out_valid), 32'd0);
        end
        pop = 1;
        @(negedge clk);
        pop = 0;
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        chk_state(req);
    endtask

    task automatic do_both(input logic [31:0] d, input string req);
        bit was_full;
        bit had;
        @(negedge clk);
        was_full = (exp_q.size() == DEPTH);
        had = (exp_q.size() > 0);
        if (had) begin
            chk({req, " left"},  out_left,  exp_q[0].l);
            chk({req, " right"}, out_right, exp_q[0].r);
        end
        wr_en = 1; wr_data = d; pop = 1;
        @(negedge clk);
        wr_en = 0; pop = 0;
        if (had) void'(exp_q.pop_front());
        model_write(d, was_full);
        chk_state(req);
    endtask

    task automatic set_cfg(input logic [1:0] m, input bit c8, input bit with_wr, input logic [31:0] d);
        @(negedge clk);
        wr_mode = m; compact8 = c8;
        wr_en = with_wr; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        exp_q.delete();
        m_right = 0; m_mode = m; m_c8 = c8;
        chk_state("R8 flush");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk_state("R1 reset");
        chk("R1 valid", 32'(out_valid), 32'd0);

        // R2 stereo: left then right
        do_write(32'h1111_0001, "R2 left");
        chk("R2 next_right", 32'(next_right), 32'd1);
        do_write(32'h2222_0002, "R2 right");
        do_write(32'h3333_0003, "R2 left");
        do_write(32'h4444_0004, "R2 right");
        do_write(32'h5555_0005, "R2 pending left");
        // R7 would be untouched here; R9 order
        do_pop("R9 order");
        do_pop("R9 order");
        do_write(32'h6666_0006, "R2 right");
        do_pop("R9 order");
        do_pop("R7 empty pop");
        do_pop("R7 empty pop");

        // R8 change with a write in the same cycle: discarded
        do_write(32'h7777_0007, "R2 left before change");
        set_cfg(2'd1, 1'b0, 1'b1, 32'hDEAD_BEEF);

        // R3 compact 16
        do_write(32'hAAAA_5555, "R3 compact16");
        do_write(32'h1234_8765, "R3 compact16");
        do_pop("R3 compact16 out");
        do_pop("R3 compact16 out");

        // R4 compact 8
        set_cfg(2'd1, 1'b1, 1'b0, '0);
        do_write(32'h1234_ABCD, "R4 compact8");
        do_write(32'hFFFF_01FE, "R4 compact8");
        do_pop("R4 compact8 out");
        do_pop("R4 compact8 out");

        // R5 mono, fill to full, R6 overflow
        set_cfg(2'd2, 1'b1, 1'b0, '0);
        for (int i = 0; i < DEPTH; i++)
            do_write(32'hC000_0000 + 32'(i), "R5 mono");
        chk("R6 full level", 32'(level), 32'd16);
        do_write(32'hBAD0_0000, "R6 drop at full");
        do_both(32'hBAD0_0001, "R6 write+pop at full");
        do_both(32'hC000_00AA, "R9 write+pop");
        for (int i = 0; i < DEPTH; i++)
            do_pop("R9 mono drain");
        do_pop("R7 empty pop mono");

        // reserved code behaves as stereo (R2)
        set_cfg(2'd3, 1'b0, 1'b0, '0);
        do_write(32'h0BAD_CAFE, "R2 code3 left");
        do_write(32'h0FEE_D00D, "R2 code3 right");
        do_pop("R2 code3 out");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule